// File: doc/BRIEF.md
# Edge Time-Stamp Capture Channel

This block records the time at which qualified transitions occur on an asynchronous input pin. A free-running timer value arrives on a bus. The pin passes through a two-flop synchronizer and a stability filter clocked by a state-time tick. When a transition qualifies, the current timer value goes into a hidden capture buffer. From there it moves into the event-time register that software reads, and an interrupt-pending pulse marks that move.

The two stages let the channel hold two time stamps before software has to act. A read strobe marks the visible value as consumed, and the buffered value then moves forward on its own. When both stages are full, a control bit decides whether a further edge is dropped or replaces the buffered stamp. In both cases an overrun pulse is raised. An optional conversion-start pulse accompanies each stamp written into the buffer.

Top module: `ecap_channel`

## Requirements
- R1: After reset `time_o` is zero and `valid_o`, `pend_o`, `ovr_o` and `adc_start_o` are low. The filter history clears to all-low.
- R2: The pin is synchronized through two flops, and it is sampled only in cycles where `tick_i` is high. A transition qualifies only when the synchronized pin was at its old level for at least 2 consecutive samples and is then at its new level for 2 consecutive samples. Timing and capture depend on whether the level stays stable for those 2 samples. Detection happens in the cycle of the second sample at the new level, and `timer_i` is captured in that cycle.
- R3: Control bits [3:2] select which edges qualify: 00 none, 01 rising, 10 falling, 11 both. Control writes take effect one cycle after `ctrl_we_i`.
- R4: With both stages empty, a qualified edge loads the buffer. One cycle later the stamp appears on `time_o`, `valid_o` rises and `pend_o` pulses for one cycle. `pend_o` is never raised at capture itself.
- R5: An edge that finds the visible register full and the buffer empty is held in the buffer, and `time_o` does not change.
- R6: A one-cycle `rd_i` while `valid_o` is high consumes the visible value. A buffered value then moves to `time_o` one cycle later with a new `pend_o` pulse. Otherwise `valid_o` falls.
- R7: When both stages are full and control bit 1 is 0, a further edge is ignored. It causes no capture, no transfer and no `pend_o`.
- R8: When both stages are full and control bit 1 is 1, a further edge replaces the buffered stamp.
- R9: An edge that arrives while both stages are full produces a one-cycle `ovr_o` pulse one cycle later, under either overwrite setting.
- R10: With control bit 0 set, `adc_start_o` pulses for one cycle, one cycle after each edge whose stamp is written into the buffer.
- R11: When `rd_i` and a qualified edge fall in the same cycle on a full channel, the read is serviced first. The edge is then stored without an overrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | State-time enable; one pin sample per high cycle |
| pin_i | input | 1 | Asynchronous event pin |
| timer_i | input | 16 | Free-running timer value |
| ctrl_we_i | input | 1 | Control register write enable |
| ctrl_wdata_i | input | 4 | Control data: [3:2] edge select, [1] overwrite, [0] conversion request |
| rd_i | input | 1 | Event-time register read strobe |
| time_o | output | 16 | Event-time register |
| valid_o | output | 1 | Event-time register holds an unread stamp |
| pend_o | output | 1 | Interrupt-pending pulse on transfer into the register |
| ovr_o | output | 1 | Capture overrun pulse |
| adc_start_o | output | 1 | Conversion-start pulse |

## Verification
A wrong buffer-full flag shows up at the ports in one of two ways. Either an edge that should have been stored raises `ovr_o`, or a stored edge never reaches `time_o` after a read. Both appear one cycle after the edge or read. A wrong visible-register flag shows as a `pend_o` pulse that is missing or extra, or as a `valid_o` level that disagrees with the read history, in the cycle after the transfer should have happened. Filter history errors show as stamps taken one sample early or late, or as glitches accepted. Comparing `time_o` every cycle against a model fed the same timer exposes such errors on the first affected edge.

// File: rtl/ecap_pkg.sv
package ecap_pkg;
  typedef enum logic [1:0] {
    SEL_NONE = 2'b00,
    SEL_RISE = 2'b01,
    SEL_FALL = 2'b10,
    SEL_BOTH = 2'b11
  } edge_sel_e;

  localparam int CTRL_W = 4;

  // packed MSB first: sel [3:2], ow [1], adc [0]
  typedef struct packed {
    edge_sel_e sel;
    logic      ow;
    logic      adc;
  } ctrl_t;
endpackage

// File: rtl/ecap_sync_filt.sv
module ecap_sync_filt #(
  parameter int SYNC_STAGES = 2,
  parameter int HOLD_TICKS  = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 tick_i,
  input  logic                 pin_i,
  input  ecap_pkg::edge_sel_e  sel_i,
  output logic                 edge_o
);
  localparam int HW = 2 * HOLD_TICKS;
  localparam logic [HW-1:0] RISE_PAT = {{HOLD_TICKS{1'b0}}, {HOLD_TICKS{1'b1}}};
  localparam logic [HW-1:0] FALL_PAT = ~RISE_PAT;

  logic [SYNC_STAGES-1:0] sync_q;
  logic [HW-1:0]          hist_q, hist_d;
  logic                   pin_s, rise, fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
  end

  assign pin_s  = sync_q[SYNC_STAGES-1];
  assign hist_d = {hist_q[HW-2:0], pin_s};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     hist_q <= '0;
    else if (tick_i) hist_q <= hist_d;
  end

  assign rise   = tick_i && (hist_d == RISE_PAT);
  assign fall   = tick_i && (hist_d == FALL_PAT);
  assign edge_o = (rise && sel_i[0]) || (fall && sel_i[1]);

  // R2
  edge_spacing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_o |=> !edge_o);
endmodule

// File: rtl/ecap_store.sv
module ecap_store #(
  parameter int TW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          edge_i,
  input  logic [TW-1:0] timer_i,
  input  logic          rd_i,
  input  logic          ow_i,
  input  logic          adc_en_i,
  output logic [TW-1:0] time_o,
  output logic          valid_o,
  output logic          pend_o,
  output logic          ovr_o,
  output logic          adc_o
);
  logic [TW-1:0] buf_q, time_q;
  logic          buf_full_q, reg_full_q;
  logic          pend_q, ovr_q, adc_q;
  logic          xfer, buf_free, take;

  // read is serviced before the edge
  assign xfer     = buf_full_q && (!reg_full_q || rd_i);
  assign buf_free = !buf_full_q || xfer;
  assign take     = edge_i && (buf_free || ow_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_q      <= '0;
      buf_full_q <= 1'b0;
    end else if (edge_i && buf_free) begin
      buf_q      <= timer_i;
      buf_full_q <= 1'b1;
    end else if (edge_i && ow_i) begin
      buf_q      <= timer_i;
    end else if (xfer) begin
      buf_full_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      time_q     <= '0;
      reg_full_q <= 1'b0;
    end else if (xfer) begin
      time_q     <= buf_q;
      reg_full_q <= 1'b1;
    end else if (rd_i) begin
      reg_full_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      ovr_q  <= 1'b0;
      adc_q  <= 1'b0;
    end else begin
      pend_q <= xfer;
      ovr_q  <= edge_i && !buf_free;
      adc_q  <= take && adc_en_i;
    end
  end

  assign time_o  = time_q;
  assign valid_o = reg_full_q;
  assign pend_o  = pend_q;
  assign ovr_o   = ovr_q;
  assign adc_o   = adc_q;

  // R4
  pend_has_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q |-> reg_full_q);
  // R5
  time_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !xfer |=> $stable(time_q));
  // R7
  no_overwrite_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_i && buf_full_q && !xfer && !ow_i) |=> $stable(buf_q));
  // R9
  overrun_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_i && buf_full_q && reg_full_q && !rd_i) |=> ovr_q);
  // R11
  read_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_i && rd_i && reg_full_q) |=> (!ovr_q && buf_full_q));
endmodule

// File: rtl/ecap_channel.sv
module ecap_channel #(
  parameter int TW          = 16,
  parameter int SYNC_STAGES = 2,
  parameter int HOLD_TICKS  = 2
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        tick_i,
  input  logic                        pin_i,
  input  logic [TW-1:0]               timer_i,
  input  logic                        ctrl_we_i,
  input  logic [ecap_pkg::CTRL_W-1:0] ctrl_wdata_i,
  input  logic                        rd_i,
  output logic [TW-1:0]               time_o,
  output logic                        valid_o,
  output logic                        pend_o,
  output logic                        ovr_o,
  output logic                        adc_start_o
);
  import ecap_pkg::*;

  ctrl_t ctrl_q;
  logic  edge_ev;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ctrl_q <= '0;
    else if (ctrl_we_i) ctrl_q <= ctrl_t'(ctrl_wdata_i);
  end

  ecap_sync_filt #(
    .SYNC_STAGES(SYNC_STAGES),
    .HOLD_TICKS (HOLD_TICKS)
  ) u_filt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_i(tick_i),
    .pin_i (pin_i),
    .sel_i (ctrl_q.sel),
    .edge_o(edge_ev)
  );

  ecap_store #(.TW(TW)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .edge_i  (edge_ev),
    .timer_i (timer_i),
    .rd_i    (rd_i),
    .ow_i    (ctrl_q.ow),
    .adc_en_i(ctrl_q.adc),
    .time_o  (time_o),
    .valid_o (valid_o),
    .pend_o  (pend_o),
    .ovr_o   (ovr_o),
    .adc_o   (adc_start_o)
  );
endmodule

// File: tb/ecap_channel_bench.sv
module ecap_channel_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b1;
  logic        pin = 1'b0;
  logic [15:0] timer = 16'h1000;
  logic        we = 1'b0;
  logic [3:0]  wdata = 4'h0;
  logic        rd = 1'b0;
  logic [15:0] time_o;
  logic        valid_o, pend_o, ovr_o, adc_o;

  int n_chk = 0, n_bad = 0, tick_div = 1;
  int c_pend = 0, c_ovr = 0, c_adc = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ecap_channel u_ecap_channel (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .pin_i(pin), .timer_i(timer),
    .ctrl_we_i(we), .ctrl_wdata_i(wdata), .rd_i(rd),
    .time_o(time_o), .valid_o(valid_o), .pend_o(pend_o), .ovr_o(ovr_o),
    .adc_start_o(adc_o)
  );

  // reference model
  logic [15:0] hq[$];
  logic [15:0] m_time;
  logic        m_valid, m_pend, m_ovr, m_adc;
  logic        m_s1, m_s2, m_lvl, m_ev, smp;
  logic [3:0]  m_ctrl;
  int          m_run, m_prev;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hq.delete();
      m_time = '0; m_valid = 0; m_pend = 0; m_ovr = 0; m_adc = 0;
      m_s1 = 0; m_s2 = 0; m_lvl = 0; m_run = 4; m_prev = 0; m_ctrl = '0;
    end else begin
      smp = m_s2; m_s2 = m_s1; m_s1 = pin;
      m_ev = 0;
      if (tick) begin
        if (smp == m_lvl) begin
          if (m_run < 100) m_run++;
        end else begin
          m_prev = m_run; m_run = 1; m_lvl = smp;
        end
        if (m_run == 2 && m_prev >= 2) m_ev = m_lvl ? m_ctrl[2] : m_ctrl[3];
      end
      if (rd) m_valid = 0;
      m_pend = 0; m_ovr = 0; m_adc = 0;
      if (hq.size() > 0 && !m_valid) begin
        m_time = hq.pop_front(); m_valid = 1; m_pend = 1;
      end
      if (m_ev) begin
        if (hq.size() == 0) begin
          hq.push_back(timer); m_adc = m_ctrl[0];
        end else begin
          m_ovr = 1;
          if (m_ctrl[1]) begin hq[0] = timer; m_adc = m_ctrl[0]; end
        end
      end
      if (we) m_ctrl = wdata;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      chk("R4 time_o", 32'(time_o), 32'(m_time));
      chk("R6 valid_o", 32'(valid_o), 32'(m_valid));
      chk("R4 pend_o", 32'(pend_o), 32'(m_pend));
      chk("R9 ovr_o", 32'(ovr_o), 32'(m_ovr));
      chk("R10 adc_start_o", 32'(adc_o), 32'(m_adc));
      if (pend_o) c_pend++;
      if (ovr_o)  c_ovr++;
      if (adc_o)  c_adc++;
    end
  end

  initial begin
    int ph;
    ph = 0;
    forever begin
      @(negedge clk);
      timer = timer + 16'd3;
      ph++;
      tick = (ph % tick_div) == 0;
    end
  end

  task automatic wait_clk(int n); repeat (n) @(negedge clk); endtask
  task automatic pulse(int hi, int lo); pin = 1; wait_clk(hi); pin = 0; wait_clk(lo); endtask
  task automatic read_once; rd = 1; wait_clk(1); rd = 0; endtask
  task automatic set_ctrl(logic [3:0] v); we = 1; wdata = v; wait_clk(1); we = 0; endtask
  task automatic clr_cnt; #1; c_pend = 0; c_ovr = 0; c_adc = 0; endtask
  task automatic exp_cnt(string tag, int p, int o, int a);
    #1;
    chk({tag, " pend count"}, 32'(c_pend), 32'(p));
    chk({tag, " ovr count"}, 32'(c_ovr), 32'(o));
    chk({tag, " adc count"}, 32'(c_adc), 32'(a));
  endtask

  task automatic finish_run;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    wait_clk(3);
    // R1
    chk("R1 time_o", 32'(time_o), 0);
    chk("R1 valid_o", 32'(valid_o), 0);
    chk("R1 pend_o", 32'(pend_o), 0);
    rst_n = 1;
    wait_clk(6);
    chk("R1 idle ovr_o", 32'(ovr_o), 0);

    // R4 R10 single rising edge into empty channel
    set_ctrl(4'b0101); wait_clk(2);
    clr_cnt(); pulse(4, 6); exp_cnt("R4", 1, 0, 1);
    chk("R4 valid after edge", 32'(valid_o), 1);
    read_once(); wait_clk(2);
    chk("R6 valid after read", 32'(valid_o), 0);

    // R5 second edge held, R7 third ignored, R6 refill
    clr_cnt(); pulse(4, 4); pulse(4, 6); exp_cnt("R5", 1, 0, 2);
    clr_cnt(); pulse(4, 6); exp_cnt("R7", 0, 1, 0);
    clr_cnt(); read_once(); wait_clk(2); exp_cnt("R6 refill", 1, 0, 0);
    clr_cnt(); read_once(); wait_clk(2); exp_cnt("R6 drain", 0, 0, 0);

    // R8 overwrite policy
    set_ctrl(4'b0111); wait_clk(2);
    pulse(4, 4); pulse(4, 6);
    clr_cnt(); pulse(4, 6); exp_cnt("R8", 0, 1, 1);
    read_once(); wait_clk(2); read_once(); wait_clk(2);

    // R3 falling only, no conversion request
    set_ctrl(4'b1000); wait_clk(2);
    clr_cnt(); pulse(4, 6); exp_cnt("R3 falling", 1, 0, 0);
    read_once(); wait_clk(2);
    // R3 both edges
    set_ctrl(4'b1100); wait_clk(2);
    clr_cnt(); pulse(4, 8); exp_cnt("R3 both", 1, 0, 0);
    chk("R3 both buffered", 32'(valid_o), 1);
    read_once(); wait_clk(2); read_once(); wait_clk(2);
    // R3 none
    set_ctrl(4'b0000); wait_clk(2);
    clr_cnt(); pulse(4, 6); exp_cnt("R3 none", 0, 0, 0);

    // R2 filter: one-sample glitch dropped, two-sample pulse kept
    set_ctrl(4'b0101); wait_clk(2);
    clr_cnt(); pulse(1, 8); exp_cnt("R2 glitch", 0, 0, 0);
    clr_cnt(); pulse(2, 8); exp_cnt("R2 short", 1, 0, 1);
    read_once(); wait_clk(2);

    // R11 read coincides with edge on a full channel
    pulse(4, 4); pulse(4, 6);
    clr_cnt();
    pin = 1; wait_clk(3); read_once(); wait_clk(4);
    exp_cnt("R11", 1, 0, 1);
    pin = 0; wait_clk(6);
    read_once(); wait_clk(2); read_once(); wait_clk(2);

    // R2 slow state time
    tick_div = 3; wait_clk(6);
    clr_cnt(); pulse(12, 15); exp_cnt("R2 slow", 1, 0, 1);
    clr_cnt(); pulse(3, 15); exp_cnt("R2 slow glitch", 0, 0, 0);
    read_once(); wait_clk(4);
    chk("R6 final valid", 32'(valid_o), 0);

    finish_run();
  end
endmodule